// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table that lives in ordinary memory. Each request carries a virtual address and an access type. A root-table base address, supplied on a plain input, is captured together with the request. The walker reads the first-level entry and then the second-level entry, one at a time, through a request/response memory port. It then reports either the translated address or a fault that says which level held the invalid entry.

Pages are 4 KB, so the low 12 address bits bypass translation. The 20-bit page number is split into two 10-bit table indices. The upper index selects the first-level entry and the lower index selects the second-level entry. Every entry is one 32-bit word. Bit 0 is its valid flag and bits 31:12 hold a 4 KB frame number. In a first-level entry that frame is the second-level table. In a second-level entry it is the data page.

The request port and the memory request port follow valid/ready rules. A transfer happens on a rising edge where both valid and ready are high. A driver keeps valid and its payload steady until that edge. The walker accepts a request only while it is idle. It keeps its memory request and address steady through any number of stall cycles. The memory response is a single-beat valid with no ready, and the walker accepts it only while waiting for the entry it asked for. The result is a one-cycle pulse with no back-pressure.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted and on the first cycle after it, req_ready is 1 and both mem_req_valid and done_valid are 0.
- R2: req_ready is 1 only while no walk is in progress. The address, access type and root base are captured on the accepting edge. Later changes to them have no effect on that walk's fetch addresses or its result.
- R3: The first memory read goes to root base + vaddr[31:22] * 4.
- R4: The second memory read goes to {first-level entry[31:12], 12'h000} + vaddr[21:12] * 4.
- R5: An entry is valid when its bit 0 is 1. All other bits below 12 are ignored.
- R6: When both entries are valid, the result has done_fault = 0 and done_paddr = {second-level entry[31:12], vaddr[11:0]}.
- R7: An invalid first-level entry ends the walk after exactly one memory read. An invalid second-level entry ends it after two. In both cases done_fault = 1 and done_paddr = 0, and done_fault_lvl is 0 for the first level and 1 for the second.
- R8: done_valid is high for exactly one cycle per accepted request, and req_ready is 1 in the cycle after that pulse.
- R9: mem_req_valid stays high with a steady mem_req_addr until mem_req_ready is seen. Any number of cycles of request stall or response delay gives the same result.
- R10: done_kind returns the access type that was captured with the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pt_base | input | 32 | Physical address of the first-level table, captured on accept |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access type, returned with the result |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Physical address of the entry to read |
| mem_rsp_valid | input | 1 | Single-beat read data valid |
| mem_rsp_data | input | 32 | Entry word read from memory |
| done_valid | output | 1 | One-cycle result strobe |
| done_fault | output | 1 | 1 when the walk met an invalid entry |
| done_fault_lvl | output | 1 | Faulting level: 0 first, 1 second |
| done_paddr | output | 32 | Translated physical address, 0 on fault |
| done_kind | output | 2 | Access type of the finished request |

## Verification
A vector table runs translations against two root tables. The first has a regular pattern of invalid entries at both levels. The second maps every index in reverse order. Together they separate the upper-index and lower-index paths, show the offset passing through, and show a fault being reported at the right level with the right number of reads. Each vector also uses a different pattern of request stall and response delay, so latency cannot change any result. Directed tests then cover reset, a very long stall, inputs that change while a walk is in flight, back-to-back requests, and the full-ones address at the top of both indices.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    WS_IDLE,
    WS_FETCH_L1,
    WS_WAIT_L1,
    WS_FETCH_L2,
    WS_WAIT_L2,
    WS_DONE,
    WS_FAULT
  } walk_state_e;
endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        mem_req_ready,
  input  logic        mem_rsp_valid,
  input  logic        rsp_entry_ok,
  output walk_state_e state_q,
  output logic        fault_lvl_q
);

  walk_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WS_IDLE:     if (req_valid)     state_d = WS_FETCH_L1;
      WS_FETCH_L1: if (mem_req_ready) state_d = WS_WAIT_L1;
      WS_WAIT_L1:  if (mem_rsp_valid) state_d = rsp_entry_ok ? WS_FETCH_L2 : WS_FAULT;
      WS_FETCH_L2: if (mem_req_ready) state_d = WS_WAIT_L2;
      WS_WAIT_L2:  if (mem_rsp_valid) state_d = rsp_entry_ok ? WS_DONE : WS_FAULT;
      WS_DONE:     state_d = WS_IDLE;
      WS_FAULT:    state_d = WS_IDLE;
      default:     state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= WS_IDLE;
      fault_lvl_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (mem_rsp_valid && !rsp_entry_ok) begin
        if (state_q == WS_WAIT_L1) fault_lvl_q <= 1'b0;
        if (state_q == WS_WAIT_L2) fault_lvl_q <= 1'b1;
      end
    end
  end

  // R7: an invalid first-level entry goes straight to a level-0 fault
  a_r7_l1_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WS_WAIT_L1 && mem_rsp_valid && !rsp_entry_ok)
      |=> (state_q == WS_FAULT && !fault_lvl_q));

  // R9: waiting for the response tolerates any delay
  a_r9_rsp_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WS_WAIT_L2 && !mem_rsp_valid) |=> (state_q == WS_WAIT_L2));

endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath #(
  parameter int ADDR_W      = 32,
  parameter int OFF_W       = 12,
  parameter int IDX_W       = 10,
  parameter int ENTRY_BYTES = 4,
  parameter int KIND_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              take_l1,
  input  logic              take_l2,
  input  logic              sel_l2,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [KIND_W-1:0] req_kind,
  input  logic [ADDR_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [ADDR_W-1:0] paddr,
  output logic [KIND_W-1:0] kind_q
);

  localparam int LEVELS  = 2;
  localparam int FRAME_W = ADDR_W - OFF_W;
  localparam int ENT_SH  = $clog2(ENTRY_BYTES);

  logic [ADDR_W-1:0]  va_q, base_q;
  logic [FRAME_W-1:0] l2_frame_q, ppn_q;
  logic [IDX_W-1:0]   idx [LEVELS];
  logic [IDX_W-1:0]   idx_sel;
  logic [ADDR_W-1:0]  tbl_base, ent_ofs;

  // Index fields, most significant level first.
  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_idx
    assign idx[lv] = va_q[ADDR_W-1-lv*IDX_W -: IDX_W];
  end

  always_comb begin
    idx_sel  = sel_l2 ? idx[1] : idx[0];
    tbl_base = sel_l2 ? {l2_frame_q, {OFF_W{1'b0}}} : base_q;
    ent_ofs  = '0;
    ent_ofs[IDX_W+ENT_SH-1:0] = {idx_sel, {ENT_SH{1'b0}}};
    fetch_addr = tbl_base + ent_ofs;
    paddr      = {ppn_q, va_q[OFF_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q       <= '0;
      base_q     <= '0;
      kind_q     <= '0;
      l2_frame_q <= '0;
      ppn_q      <= '0;
    end else begin
      if (accept) begin
        va_q   <= req_vaddr;
        base_q <= req_base;
        kind_q <= req_kind;
      end
      if (take_l1) l2_frame_q <= rsp_data[ADDR_W-1:OFF_W];
      if (take_l2) ppn_q      <= rsp_data[ADDR_W-1:OFF_W];
    end
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int OFF_W       = 12,
  parameter int IDX_W       = 10,
  parameter int ENTRY_BYTES = 4,
  parameter int KIND_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] pt_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [KIND_W-1:0] req_kind,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              done_valid,
  output logic              done_fault,
  output logic              done_fault_lvl,
  output logic [ADDR_W-1:0] done_paddr,
  output logic [KIND_W-1:0] done_kind
);

  walk_state_e       state_q;
  logic              fault_lvl_q;
  logic              entry_ok;
  logic              accept, take_l1, take_l2, sel_l2;
  logic [ADDR_W-1:0] paddr;
  logic              unused_entry_bits;

  assign entry_ok          = mem_rsp_data[0];
  assign unused_entry_bits = ^mem_rsp_data[OFF_W-1:1];

  assign req_ready     = (state_q == WS_IDLE);
  assign accept        = req_valid && req_ready;
  assign take_l1       = (state_q == WS_WAIT_L1) && mem_rsp_valid && entry_ok;
  assign take_l2       = (state_q == WS_WAIT_L2) && mem_rsp_valid && entry_ok;
  assign sel_l2        = (state_q == WS_FETCH_L2);
  assign mem_req_valid = (state_q == WS_FETCH_L1) || (state_q == WS_FETCH_L2);

  assign done_valid     = (state_q == WS_DONE) || (state_q == WS_FAULT);
  assign done_fault     = (state_q == WS_FAULT);
  assign done_fault_lvl = done_fault && fault_lvl_q;
  assign done_paddr     = (state_q == WS_DONE) ? paddr : '0;

  ptw_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_entry_ok  (entry_ok),
    .state_q       (state_q),
    .fault_lvl_q   (fault_lvl_q)
  );

  ptw_datapath #(
    .ADDR_W      (ADDR_W),
    .OFF_W       (OFF_W),
    .IDX_W       (IDX_W),
    .ENTRY_BYTES (ENTRY_BYTES),
    .KIND_W      (KIND_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .take_l1    (take_l1),
    .take_l2    (take_l2),
    .sel_l2     (sel_l2),
    .req_vaddr  (req_vaddr),
    .req_base   (pt_base),
    .req_kind   (req_kind),
    .rsp_data   (mem_rsp_data),
    .fetch_addr (mem_req_addr),
    .paddr      (paddr),
    .kind_q     (done_kind)
  );

  // R9: a stalled memory request holds valid and address
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R8: the result strobe lasts one cycle and the walker is idle after it
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> (!done_valid && req_ready));

  // R2: no new request is taken while memory traffic is pending
  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  // R2, R3: an accepted request starts the first-level read next cycle
  a_r2_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (mem_req_valid && !req_ready));

endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;

  localparam logic [31:0] BASE_A = 32'h0010_0000;
  localparam logic [31:0] BASE_B = 32'h0020_0000;

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] va;
    logic        fault;
    logic        lvl;
    logic [31:0] pa;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{BASE_A, 32'h0000_0ABC, 1'b0, 1'b0, 32'hF0F0_FABC},
    '{BASE_A, 32'h0040_1123, 1'b0, 1'b0, 32'hF0B0_E123},
    '{BASE_A, 32'h0080_0000, 1'b1, 1'b0, 32'h0000_0000},
    '{BASE_A, 32'h0040_4FFF, 1'b1, 1'b1, 32'h0000_0000},
    '{BASE_A, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0F0F_0FFF},
    '{BASE_B, 32'h0000_0ABC, 1'b0, 1'b0, 32'h0F30_FABC},
    '{BASE_B, 32'h0080_0010, 1'b0, 1'b0, 32'h0FB0_F010},
    '{BASE_B, 32'h0000_9000, 1'b1, 1'b1, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pt_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done_valid, done_fault, done_fault_lvl;
  logic [31:0] done_paddr;
  logic [1:0]  done_kind;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pt_walker uut (
    .clk(clk), .rst_n(rst_n), .pt_base(pt_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_kind(req_kind),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done_valid(done_valid), .done_fault(done_fault), .done_fault_lvl(done_fault_lvl),
    .done_paddr(done_paddr), .done_kind(done_kind)
  );

  // Synthetic page tables held by the bench memory.
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] i, t, j;
    logic [19:0] fr;
    if (a >= BASE_A && a < BASE_A + 32'h1000) begin
      i = (a - BASE_A) >> 2;
      if (i % 3 == 2) return 32'hFFFF_FFFE;
      fr = 20'h01000 + i[19:0];
      return {fr, 12'h001};
    end
    if (a >= BASE_B && a < BASE_B + 32'h1000) begin
      i = (a - BASE_B) >> 2;
      fr = 20'h01000 + 20'(1023 - i);
      return {fr, 12'h001};
    end
    if (a >= 32'h0100_0000 && a < 32'h0140_0000) begin
      t = (a >> 12) & 32'h3FF;
      j = (a >> 2) & 32'h3FF;
      if (j % 5 == 4) return 32'h0000_0FFE;
      fr = {t[9:0], j[9:0]} ^ 20'hF0F0F;
      return {fr, 12'h001};
    end
    return 32'hDEAD_0000;
  endfunction

  // Memory responder with programmable stalls.
  int          rdy_lat = 0, rsp_lat = 0, rcnt = 0, scnt = 0;
  int          fetch_n = 0;
  logic [31:0] fetch_log [4];
  bit          pending = 0;
  logic [31:0] pend_addr = '0;
  bit          prev_v = 0, prev_r = 0;
  logic [31:0] prev_a = '0;

  initial begin
    forever begin
      @(negedge clk);
      if (prev_v && prev_r) begin
        pending = 1;
        pend_addr = prev_a;
        scnt = rsp_lat;
        if (fetch_n < 4) fetch_log[fetch_n] = prev_a;
        fetch_n++;
      end
      mem_rsp_valid = 1'b0;
      if (pending) begin
        if (scnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_word(pend_addr);
          pending = 0;
        end else scnt--;
      end
      if (mem_req_valid && !pending) begin
        if (rcnt == 0) mem_req_ready = 1'b1;
        else begin mem_req_ready = 1'b0; rcnt--; end
      end else begin
        mem_req_ready = 1'b0;
        rcnt = rdy_lat;
      end
      prev_v = mem_req_valid;
      prev_r = mem_req_ready;
      prev_a = mem_req_addr;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Walk results seen by the last run
  logic        r_fault, r_lvl, r_timeout, r_busy_ready, r_post_valid, r_post_ready;
  logic [31:0] r_pa;
  logic [1:0]  r_kind;

  task automatic run_walk(input logic [31:0] b, input logic [31:0] va, input logic [1:0] k,
                          input int rl, input int sl, input bit swap);
    int n;
    @(negedge clk);
    n = 0;
    while (!req_ready && n < 100) begin @(negedge clk); n++; end
    rdy_lat = rl; rsp_lat = sl; rcnt = rl; fetch_n = 0;
    req_valid = 1'b1; req_vaddr = va; pt_base = b; req_kind = k;
    @(negedge clk);
    req_valid = 1'b0;
    r_busy_ready = req_ready;
    if (swap) begin
      pt_base = BASE_B ^ b ^ BASE_A;
      req_vaddr = ~va;
      req_kind = ~k;
    end
    n = 0;
    while (!done_valid && n < 3000) begin @(negedge clk); n++; end
    r_timeout = !done_valid;
    r_fault = done_fault; r_lvl = done_fault_lvl; r_pa = done_paddr; r_kind = done_kind;
    @(negedge clk);
    r_post_valid = done_valid;
    r_post_ready = req_ready;
  endtask

  task automatic check_walk(input vec_t v, input logic [1:0] k, input string name);
    logic [31:0] e1, exp_f0, exp_f1;
    int exp_n;
    exp_f0 = v.base + {20'h0, v.va[31:22], 2'b00};
    e1 = mem_word(exp_f0);
    exp_f1 = {e1[31:12], 12'h000} + {20'h0, v.va[21:12], 2'b00};
    exp_n = (v.fault && !v.lvl) ? 1 : 2;
    chk(!r_timeout, {name, " R9 completes"}, 32'(r_timeout), 0);
    chk(r_busy_ready == 1'b0, {name, " R2 busy"}, 32'(r_busy_ready), 0);
    chk(r_fault == v.fault, {name, " R6/R7 fault"}, 32'(r_fault), 32'(v.fault));
    if (v.fault) chk(r_lvl == v.lvl, {name, " R7 level"}, 32'(r_lvl), 32'(v.lvl));
    chk(r_pa == v.pa, {name, " R6 paddr"}, r_pa, v.pa);
    chk(fetch_n == exp_n, {name, " R7 read count"}, 32'(fetch_n), 32'(exp_n));
    chk(fetch_log[0] == exp_f0, {name, " R3 first addr"}, fetch_log[0], exp_f0);
    if (exp_n == 2) chk(fetch_log[1] == exp_f1, {name, " R4 second addr"}, fetch_log[1], exp_f1);
    chk(r_kind == k, {name, " R10 kind"}, 32'(r_kind), 32'(k));
    chk(!r_post_valid && r_post_ready, {name, " R8 pulse/idle"},
        {30'h0, r_post_valid, r_post_ready}, 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R9 actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_req_valid && !done_valid, "R1 in reset",
        {29'h0, req_ready, mem_req_valid, done_valid}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_req_valid && !done_valid, "R1 after reset",
        {29'h0, req_ready, mem_req_valid, done_valid}, 32'h4);

    // Table of vectors, each with its own stall pattern (R9)
    for (int k = 0; k < NV; k++) begin
      run_walk(VECS[k].base, VECS[k].va, 2'(k), (k % 3) * 2, (k * 3) % 4, 1'b0);
      check_walk(VECS[k], 2'(k), $sformatf("vec%0d", k));
    end

    // R9: very long stalls on both request and response
    run_walk(VECS[1].base, VECS[1].va, 2'd3, 40, 25, 1'b0);
    check_walk(VECS[1], 2'd3, "long stall R9");

    // R2: inputs change right after acceptance; the walk uses captured values
    run_walk(VECS[6].base, VECS[6].va, 2'd2, 1, 1, 1'b1);
    check_walk(VECS[6], 2'd2, "swap inputs R2");

    // R5: entry low bits other than bit 0 are ignored (fault vector entry 0xFFFFFFFE)
    run_walk(VECS[2].base, VECS[2].va, 2'd1, 0, 0, 1'b0);
    check_walk(VECS[2], 2'd1, "low bits R5");

    // R8: back-to-back requests with no gap
    run_walk(VECS[4].base, VECS[4].va, 2'd0, 0, 0, 1'b0);
    check_walk(VECS[4], 2'd0, "b2b first R8");
    run_walk(VECS[7].base, VECS[7].va, 2'd3, 0, 0, 1'b0);
    check_walk(VECS[7], 2'd3, "b2b second R8");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule